// File: doc/BRIEF.md
# Paged Data-Flash Access Controller

This block sits between an 8-bit processor's external-data port and a 128 KB flash array. The flash is seen as one combined space: the lower 64 KB holds program code and the upper 64 KB holds data. The processor reads data flash in two ways. The first is a full 16-bit pointer. The second is a paged path, where a page register supplies the high address byte and an 8-bit index register supplies the low byte. Both read paths always land in the data half, because address bit 16 is forced high.

Writes from the processor never reach the flash, on either path. The flash changes only through in-system commands: byte program, page erase, chip erase and chip protect. For the two commands that depend on an address, bit 16 of the flash address comes from a bit in a control register. Software sets that bit beforehand to choose between code and data flash.

Once a protect command has run, every read returns zero. The flag stays set until reset or until a chip erase.

The read path follows valid/ready rules on both sides:
- A request is accepted on any cycle where `cpu_req_valid` and `cpu_req_ready` are both high.
- `cpu_req_ready` is low only while a response is being held, meaning `cpu_rsp_valid` is high and `cpu_rsp_ready` is low.
- A held response keeps its data unchanged until the consumer takes it.

The register-access pins and the command pins are plain strobes with no handshake.

Top module: `dflash_page_ctrl`

## Requirements
- R1: After reset the page register and the control register read 0x00, the protect flag is clear and `cpu_rsp_valid` is low.
- R2: A read accepted with `cpu_req_paged`=0 drives `fl_rd_en` high in the same cycle, with `fl_rd_addr` = {1, `cpu_dptr`}. On the next cycle `cpu_rsp_valid` is high and `cpu_rsp_data` holds the byte that the flash returned for that address.
- R3: A read accepted with `cpu_req_paged`=1 addresses the flash at {1, page register, `cpu_idx`}, with the same one-cycle response timing as R2.
- R4: An accepted write, with `cpu_req_write`=1 on either path, never raises `fl_rd_en`, never issues a flash command and produces no response.
- R5: Register writes take effect at the clock edge of the strobe.
  - Address 0x85 holds the page register and address 0xF7 holds the control register.
  - `sfr_rdata` shows the current value of the register selected by `sfr_addr`, and 0x00 for any other address.
  - Writes to any other address change nothing.
- R6: A program command (op 0) or page-erase command (op 1) puts control-register bit 0 on `fl_cmd_addr[16]` and `isp_addr` on the low 16 bits. Chip erase (op 2) and protect (op 3) carry address 0. `fl_cmd_data` equals `isp_wdata` for op 0 and is 0x00 otherwise.
- R7: After a protect command (op 3), every read response carries 0x00. The flag stays set through other commands and is cleared only by a chip erase (op 2) or reset. A read accepted in the same cycle as the command uses the flag value from before that command.
- R8: `cpu_req_ready` equals `!cpu_rsp_valid || cpu_rsp_ready`. While `cpu_rsp_valid` is high and `cpu_rsp_ready` is low, both the valid and the data hold.
- R9: `fl_cmd_valid` follows `isp_go` in the same cycle, and `fl_cmd_op` equals `isp_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Access request valid |
| cpu_req_ready | output | 1 | Request can be accepted |
| cpu_req_write | input | 1 | 1 = write attempt (ignored), 0 = read |
| cpu_req_paged | input | 1 | 1 = page+index path, 0 = 16-bit pointer |
| cpu_dptr | input | 16 | 16-bit data pointer |
| cpu_idx | input | 8 | Index register value (low address byte) |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_ready | input | 1 | Consumer takes read data |
| cpu_rsp_data | output | 8 | Read data |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Current value of addressed register |
| isp_go | input | 1 | In-system command strobe |
| isp_op | input | 2 | 0 program, 1 page erase, 2 chip erase, 3 protect |
| isp_addr | input | 16 | Command address, low 16 bits |
| isp_wdata | input | 8 | Byte to program |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_rd_addr | output | 17 | Flash read address |
| fl_rd_data | input | 8 | Flash read data (combinational with address) |
| fl_cmd_valid | output | 1 | Flash command strobe |
| fl_cmd_op | output | 2 | Flash command code |
| fl_cmd_addr | output | 17 | Flash command address |
| fl_cmd_data | output | 8 | Flash program data |

## Verification
Pointer reads are run at the bottom, the top and the middle of the 64 KB window. They show that bit 16 is forced high and that the full pointer is passed through. Paged reads are run after the page register is set to several values. Their results change only with the page, which separates the page byte from the index byte. A read held under back-pressure, followed by a queued request, shows that the data holds and that acceptance waits.

Each command type is issued with the control bit both clear and set, which shows which commands take bit 16 from the register. Reads issued before a protect, in the same cycle as it, after it, and after the chip erase that clears it pin down when the zeroing takes effect.

// File: rtl/dfpc_pkg.sv
package dfpc_pkg;
  typedef enum logic [1:0] {
    ISP_PROG       = 2'd0,
    ISP_PAGE_ERASE = 2'd1,
    ISP_CHIP_ERASE = 2'd2,
    ISP_PROTECT    = 2'd3
  } isp_op_e;
endpackage

// File: rtl/dfpc_sfr_bank.sv
module dfpc_sfr_bank #(
  parameter int DATA_W   = 8,
  parameter int PAGE_SEL = 8'h85,
  parameter int CTRL_SEL = 8'hF7,
  parameter int FAU_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] page_o,
  output logic              fau_o
);
  logic [DATA_W-1:0] page_q, ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      if (addr == 8'(PAGE_SEL)) page_q <= wdata;
      if (addr == 8'(CTRL_SEL)) ctrl_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 8'(PAGE_SEL))      rdata = page_q;
    else if (addr == 8'(CTRL_SEL)) rdata = ctrl_q;
  end

  assign page_o = page_q;
  assign fau_o  = ctrl_q[FAU_BIT];

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'(PAGE_SEL)) |=> page_q == $past(wdata)); // R5
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 8'(PAGE_SEL)) |=> $stable(page_q)); // R5
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'(CTRL_SEL)) |=> ctrl_q == $past(wdata)); // R5
endmodule

// File: rtl/dfpc_read_path.sv
module dfpc_read_path #(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W,
  localparam int FA_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_paged,
  input  logic [PTR_W-1:0]  dptr,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] page,
  input  logic              prot,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rd_en,
  output logic [FA_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic accept;
  logic [PTR_W-1:0] offset;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_en     = accept && !req_write;
  assign offset    = req_paged ? {page, idx} : dptr;
  assign rd_addr   = {1'b1, offset};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= prot ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RD_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[FA_W-1]); // R2
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid); // R2
  AST_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid); // R4
  AST_PROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && prot) |=> rsp_data == '0); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R8
endmodule

// File: rtl/dfpc_isp_path.sv
module dfpc_isp_path
  import dfpc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W,
  localparam int FA_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        op,
  input  logic [PTR_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fau,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [FA_W-1:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              prot_o
);
  isp_op_e op_e;
  logic    addr_cmd;
  logic    prot_q;

  assign op_e     = isp_op_e'(op);
  assign addr_cmd = (op_e == ISP_PROG) || (op_e == ISP_PAGE_ERASE);

  assign cmd_valid = go;
  assign cmd_op    = op;
  assign cmd_addr  = addr_cmd ? {fau, addr} : '0;
  assign cmd_data  = (op_e == ISP_PROG) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                             prot_q <= 1'b0;
    else if (go && op_e == ISP_PROTECT)     prot_q <= 1'b1;
    else if (go && op_e == ISP_CHIP_ERASE)  prot_q <= 1'b0;
  end

  assign prot_o = prot_q;

  AST_PROT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_e == ISP_PROTECT) |=> prot_q); // R7
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !(go && op_e == ISP_CHIP_ERASE)) |=> prot_q); // R7
  AST_FA16_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && addr_cmd) |-> cmd_addr[FA_W-1] == fau); // R6
endmodule

// File: rtl/dflash_page_ctrl.sv
module dflash_page_ctrl #(
  parameter int DATA_W   = 8,
  parameter int PAGE_SEL = 8'h85,
  parameter int CTRL_SEL = 8'hF7,
  parameter int FAU_BIT  = 0,
  localparam int PTR_W   = 2 * DATA_W,
  localparam int FA_W    = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic              cpu_req_paged,
  input  logic [PTR_W-1:0]  cpu_dptr,
  input  logic [DATA_W-1:0] cpu_idx,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_data,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              isp_go,
  input  logic [1:0]        isp_op,
  input  logic [PTR_W-1:0]  isp_addr,
  input  logic [DATA_W-1:0] isp_wdata,
  output logic              fl_rd_en,
  output logic [FA_W-1:0]   fl_rd_addr,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [FA_W-1:0]   fl_cmd_addr,
  output logic [DATA_W-1:0] fl_cmd_data
);
  logic [DATA_W-1:0] page;
  logic              fau;
  logic              prot;

  dfpc_sfr_bank #(
    .DATA_W(DATA_W), .PAGE_SEL(PAGE_SEL), .CTRL_SEL(CTRL_SEL), .FAU_BIT(FAU_BIT)
  ) u_sfr (
    .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .rdata(sfr_rdata), .page_o(page), .fau_o(fau)
  );

  dfpc_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready),
    .req_write(cpu_req_write), .req_paged(cpu_req_paged),
    .dptr(cpu_dptr), .idx(cpu_idx), .page(page), .prot(prot),
    .rsp_valid(cpu_rsp_valid), .rsp_ready(cpu_rsp_ready), .rsp_data(cpu_rsp_data),
    .rd_en(fl_rd_en), .rd_addr(fl_rd_addr), .rd_data(fl_rd_data)
  );

  dfpc_isp_path #(.DATA_W(DATA_W)) u_isp (
    .clk(clk), .rst_n(rst_n), .go(isp_go), .op(isp_op), .addr(isp_addr),
    .wdata(isp_wdata), .fau(fau),
    .cmd_valid(fl_cmd_valid), .cmd_op(fl_cmd_op), .cmd_addr(fl_cmd_addr),
    .cmd_data(fl_cmd_data), .prot_o(prot)
  );

  AST_WR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && !isp_go) |-> !fl_cmd_valid && !fl_rd_en); // R4
  AST_CMD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    isp_go |-> fl_cmd_valid && fl_cmd_op == isp_op); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> !cpu_rsp_valid); // R1
endmodule

// File: tb/dflash_page_ctrl_bench.sv
`timescale 1ns/1ps
module dflash_page_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_v, req_r, req_w, req_p, rsp_v, rsp_r, sfr_we, isp_go;
  logic fl_rd_en, fl_cmd_valid;
  logic [15:0] dptr, isp_addr;
  logic [7:0]  idx, rsp_d, sfr_addr, sfr_wdata, sfr_rdata, isp_wdata, fl_rd_data, fl_cmd_data;
  logic [1:0]  isp_op, fl_cmd_op;
  logic [16:0] fl_rd_addr, fl_cmd_addr;

  function automatic logic [7:0] flash_byte(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ (a[16] ? 8'hA5 : 8'h00) ^ 8'h3C;
  endfunction
  assign fl_rd_data = flash_byte(fl_rd_addr);

  dflash_page_ctrl u_dflash_page_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(req_v), .cpu_req_ready(req_r),
    .cpu_req_write(req_w), .cpu_req_paged(req_p), .cpu_dptr(dptr), .cpu_idx(idx),
    .cpu_rsp_valid(rsp_v), .cpu_rsp_ready(rsp_r), .cpu_rsp_data(rsp_d),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .isp_go(isp_go), .isp_op(isp_op), .isp_addr(isp_addr), .isp_wdata(isp_wdata),
    .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
    .fl_cmd_valid(fl_cmd_valid), .fl_cmd_op(fl_cmd_op), .fl_cmd_addr(fl_cmd_addr),
    .fl_cmd_data(fl_cmd_data)
  );

  int total = 0, bad = 0;
  logic [7:0] m_page, m_ctrl, m_rd;
  bit m_prot, m_rv, m_rp;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_rd();
    return req_v && (!m_rv || rsp_r) && !req_w;
  endfunction
  function automatic logic [16:0] exp_addr();
    return req_p ? {1'b1, m_page, idx} : {1'b1, dptr};
  endfunction

  task automatic compare_all();
    logic [7:0] es;
    chk("R8 req_ready", req_r, !m_rv || rsp_r);
    chk(req_w ? "R4 rd_en on write" : "R2 rd_en", fl_rd_en, exp_rd());
    if (exp_rd()) chk(req_p ? "R3 paged addr" : "R2 pointer addr", fl_rd_addr, exp_addr());
    chk("R8 rsp_valid", rsp_v, m_rv);
    if (m_rv) chk(m_rp ? "R7 protected data" : "R2 read data", rsp_d, m_rd);
    es = (sfr_addr == 8'h85) ? m_page : (sfr_addr == 8'hF7) ? m_ctrl : 8'h00;
    chk("R5 sfr_rdata", sfr_rdata, es);
    chk(req_w ? "R4 no cmd on write" : "R9 cmd_valid", fl_cmd_valid, isp_go);
    if (isp_go) begin
      chk("R9 cmd_op", fl_cmd_op, isp_op);
      chk("R6 cmd_addr", fl_cmd_addr, (isp_op < 2) ? {m_ctrl[0], isp_addr} : 17'h0);
      chk("R6 cmd_data", fl_cmd_data, (isp_op == 0) ? isp_wdata : 8'h00);
    end
  endtask

  task automatic update_model();
    if (exp_rd()) begin
      m_rv = 1; m_rp = m_prot;
      m_rd = m_prot ? 8'h00 : flash_byte(exp_addr());
    end else if (rsp_r) m_rv = 0;
    if (sfr_we && sfr_addr == 8'h85) m_page = sfr_wdata;
    if (sfr_we && sfr_addr == 8'hF7) m_ctrl = sfr_wdata;
    if (isp_go && isp_op == 2'd3) m_prot = 1;
    else if (isp_go && isp_op == 2'd2) m_prot = 0;
  endtask

  task automatic cyc();
    #1;
    compare_all();
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic idle();
    req_v = 0; req_w = 0; req_p = 0; rsp_r = 1; sfr_we = 0; isp_go = 0;
    isp_op = 0; isp_addr = 16'h0; isp_wdata = 8'h0; sfr_wdata = 8'h0;
  endtask

  task automatic rd_ptr(logic [15:0] a);
    idle(); req_v = 1; dptr = a; cyc();
  endtask
  task automatic rd_pg(logic [7:0] i);
    idle(); req_v = 1; req_p = 1; idx = i; cyc();
  endtask
  task automatic sfr_w(logic [7:0] a, logic [7:0] d);
    idle(); sfr_we = 1; sfr_addr = a; sfr_wdata = d; cyc();
  endtask
  task automatic isp(logic [1:0] op, logic [15:0] a, logic [7:0] d);
    idle(); isp_go = 1; isp_op = op; isp_addr = a; isp_wdata = d; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); dptr = 16'h0; idx = 8'h0; sfr_addr = 8'h85;
    m_page = 0; m_ctrl = 0; m_prot = 0; m_rv = 0; m_rp = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rsp_valid after reset", rsp_v, 1'b0);
    chk("R1 page after reset", sfr_rdata, 8'h00);
    sfr_addr = 8'hF7; #1;
    chk("R1 ctrl after reset", sfr_rdata, 8'h00);
    @(negedge clk); rst_n = 1;
    rd_ptr(16'h0000);
    chk("R1 not protected after reset", rsp_v && rsp_d != 8'h00, 1'b1);
    rd_ptr(16'hFFFF); rd_ptr(16'h1234); idle(); cyc();
    rd_pg(8'h00);
    sfr_w(8'h85, 8'h3C); sfr_addr = 8'h85; idle(); cyc();
    rd_pg(8'h00); rd_pg(8'hFF); rd_pg(8'h7E);
    sfr_w(8'h85, 8'hFF); rd_pg(8'h01);
    sfr_w(8'h40, 8'h11); sfr_addr = 8'h85; idle(); cyc();
    sfr_addr = 8'h40; idle(); cyc();
    sfr_addr = 8'h85;
    idle(); req_v = 1; req_w = 1; req_p = 1; idx = 8'h22; cyc();
    idle(); cyc();
    idle(); req_v = 1; req_w = 1; dptr = 16'hABCD; cyc();
    idle(); cyc();
    rd_ptr(16'h0055);
    idle(); rsp_r = 0; req_v = 1; dptr = 16'h00AA; cyc();
    idle(); rsp_r = 0; req_v = 1; dptr = 16'h00AA; cyc();
    idle(); rsp_r = 0; req_v = 1; dptr = 16'h00AA; cyc();
    idle(); rsp_r = 1; req_v = 1; dptr = 16'h00AA; cyc();
    idle(); cyc();
    sfr_w(8'hF7, 8'h00); sfr_addr = 8'hF7;
    isp(2'd0, 16'h1234, 8'hAB); isp(2'd1, 16'h8000, 8'hCD);
    sfr_w(8'hF7, 8'h01);
    isp(2'd0, 16'h4321, 8'h5A); isp(2'd1, 16'hFF00, 8'h77);
    isp(2'd2, 16'hFFFF, 8'h99);
    rd_ptr(16'h0102);
    idle(); isp_go = 1; isp_op = 2'd3; req_v = 1; dptr = 16'h0304; cyc();
    rd_ptr(16'h0506); rd_pg(8'h10);
    isp(2'd0, 16'h0001, 8'h01); isp(2'd1, 16'h0002, 8'h00);
    rd_ptr(16'h0708);
    chk("R7 zero while protected", rsp_d, 8'h00);
    isp(2'd2, 16'h0000, 8'h00);
    rd_ptr(16'h0708); idle(); cyc();
    idle(); cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule